// File: doc/BRIEF.md
# Rectifier Idle-Mode and Soft-Start Sequencer

This block supervises a two-channel synchronous rectifier controller. It watches per-cycle drain switching strobes from both channels and the two conduction flags. From these it decides when the gate drivers may fire, when they should run at the reduced gate voltage, and when the controller should fall back into one of two idle levels. After power-up it holds the gates off for a fixed number of switching cycles. It then lets them run at the reduced level until the regulation loop reports that light load has cleared.

An idle timer runs while both channels are silent, meaning no strobe and no conduction flag. It counts in ticks of a prescaled clock. The first timeout emits a single short pulse that resets the dead-time regulation loop, and it forces the turn-on delay flag high. The second, longer timeout puts the block into deep idle with the gates off. A protection trip forces the same deep idle at once. Leaving deep idle takes a fixed number of fresh switching cycles before the gates are enabled again.

Top module: `sr_idle_seq`

## Requirements
- R1: While reset is asserted and just after release, gate_en, dly_en, loop_rst_pulse, idle_shallow and idle_deep are all 0.
- R2: After reset, gate_en stays 0 until SKIP_CYCLES switching strobes have been seen, where a strobe is a clock with sw_strobe_a or sw_strobe_b high. It becomes 1 in the clock after the edge that samples the last of them, and at that point gate_low_v is 1.
- R3: The soft-start low-voltage phase ends at the first clock edge that samples light_load low. After that, gate_low_v no longer reflects soft start.
- R4: A clock in which any strobe or either conduction flag is high restarts the idle timer. After IDLE1_TICKS*PRESCALE consecutive quiet clock edges, loop_rst_pulse is 1 for exactly PULSE_CYCLES clocks. It is not repeated while the quiet interval lasts.
- R5: The regulation-reset pulse sets dly_en and idle_shallow. dly_en clears at an edge that samples a strobe while light_load is low.
- R6: After IDLE2_TICKS*PRESCALE consecutive quiet edges, idle_deep becomes 1 and gate_en becomes 0.
- R7: In deep idle, gate_en stays 0 until EXIT_CYCLES strobes have been seen. After the edge that samples the last of them, idle_deep is 0 and gate_en is 1.
- R8: A high prot_trip forces gate_en to 0 in the same cycle, and idle_deep is 1 after the next edge.
- R9: gate_low_v is 1 whenever light_load or ot_hot is high. Once ot_hot has been seen, gate_low_v stays 1 until an edge samples ot_clear high with ot_hot low.
- R10: idle_shallow returns to 0 at the first edge that samples a strobe or a conduction flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_strobe_a | input | 1 | Switching-cycle strobe, channel A |
| sw_strobe_b | input | 1 | Switching-cycle strobe, channel B |
| cond_a | input | 1 | Rectifier conduction flag, channel A |
| cond_b | input | 1 | Rectifier conduction flag, channel B |
| light_load | input | 1 | Light-load flag from the regulation loop |
| prot_trip | input | 1 | Primary-shutdown or abnormal-drain protection event |
| ot_hot | input | 1 | Over-temperature flag |
| ot_clear | input | 1 | Temperature below reset level |
| gate_en | output | 1 | Gate drivers may fire |
| gate_low_v | output | 1 | Select reduced gate voltage |
| dly_en | output | 1 | Extra turn-on delay enable |
| loop_rst_pulse | output | 1 | Reset pulse for the dead-time regulation loop |
| idle_shallow | output | 1 | First idle level reached |
| idle_deep | output | 1 | Deep idle (including the exit count) |

## Verification
The hardest situation to reach from the ports is deep idle entered from a quiet interval while protection, conduction flags and the exit count interleave with it. Reaching it needs long stretches with every activity input low, and a single stray conduction flag silently restarts the timer. The bench overrides the timeouts to a few tens of prescaled ticks. Directed steps cross both thresholds at exact edge counts, and random segments alternate bursty switching with quiet stretches longer than the deep timeout, so both idle levels and exits occur repeatedly.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [2:0] {
    ST_SKIP  = 3'd0,
    ST_SSLOW = 3'd1,
    ST_RUN   = 3'd2,
    ST_DEEP  = 3'd3,
    ST_EXIT  = 3'd4
  } sis_state_e;

  function automatic int cnt_width(input int max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sis_idle_timer.sv
module sis_idle_timer #(
  parameter int PRESCALE    = 250,
  parameter int IDLE1_TICKS = 6000,
  parameter int IDLE2_TICKS = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic quiet,
  output logic shallow_trig,
  output logic deep_trig
);
  localparam int IW = sis_pkg::cnt_width(IDLE2_TICKS);
  localparam logic [IW-1:0] I1_LAST = IW'(IDLE1_TICKS - 1);
  localparam logic [IW-1:0] I2_LAST = IW'(IDLE2_TICKS - 1);
  localparam logic [IW-1:0] I2_FULL = IW'(IDLE2_TICKS);

  logic          tick;
  logic [IW-1:0] idle_q, idle_d;

  generate
    if (PRESCALE > 1) begin : g_pre
      localparam int PW = sis_pkg::cnt_width(PRESCALE - 1);
      localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        tick = quiet && (pre_q == P_LAST);
        if (!quiet || tick) pre_d = '0;
        else                pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end
    end else begin : g_nopre
      assign tick = quiet;
    end
  endgenerate

  always_comb begin
    idle_d       = idle_q;
    shallow_trig = 1'b0;
    deep_trig    = 1'b0;
    if (!quiet) begin
      idle_d = '0;
    end else if (tick && (idle_q != I2_FULL)) begin
      idle_d       = idle_q + 1'b1;
      shallow_trig = (idle_q == I1_LAST);
      deep_trig    = (idle_q == I2_LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_q <= '0;
    else        idle_q <= idle_d;
  end
endmodule

// File: rtl/sis_loop_reset.sv
module sis_loop_reset #(
  parameter int PULSE_CYCLES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shallow_trig,
  input  logic active,
  input  logic sw_any,
  input  logic light_load,
  output logic loop_rst_pulse,
  output logic idle_shallow,
  output logic dly_en
);
  localparam int PCW = sis_pkg::cnt_width(PULSE_CYCLES);
  localparam logic [PCW-1:0] P_LEN = PCW'(PULSE_CYCLES);

  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           sh_q, sh_d;
  logic           dly_q, dly_d;

  always_comb begin
    pcnt_d = pcnt_q;
    if (shallow_trig)        pcnt_d = P_LEN;
    else if (pcnt_q != '0)   pcnt_d = pcnt_q - 1'b1;

    sh_d = sh_q;
    if (active)              sh_d = 1'b0;
    else if (shallow_trig)   sh_d = 1'b1;

    dly_d = dly_q;
    if (shallow_trig)                dly_d = 1'b1;
    else if (sw_any && !light_load)  dly_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      sh_q   <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      pcnt_q <= pcnt_d;
      sh_q   <= sh_d;
      dly_q  <= dly_d;
    end
  end

  assign loop_rst_pulse = (pcnt_q != '0);
  assign idle_shallow   = sh_q;
  assign dly_en         = dly_q;
endmodule

// File: rtl/sis_seq_fsm.sv
module sis_seq_fsm #(
  parameter int SKIP_CYCLES = 256,
  parameter int EXIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_any,
  input  logic light_load,
  input  logic prot_trip,
  input  logic deep_trig,
  output logic gate_run,
  output logic soft_low,
  output logic in_deep
);
  import sis_pkg::*;

  localparam int CMAX = (SKIP_CYCLES > EXIT_CYCLES) ? SKIP_CYCLES : EXIT_CYCLES;
  localparam int CW   = cnt_width(CMAX);
  localparam logic [CW-1:0] SKIP_LAST = CW'(SKIP_CYCLES - 1);
  localparam logic [CW-1:0] EXIT_LAST = CW'(EXIT_CYCLES - 1);

  sis_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (prot_trip) begin
      st_d  = ST_DEEP;
      cnt_d = '0;
    end else if (deep_trig && (st_q != ST_DEEP)) begin
      st_d  = ST_DEEP;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_SKIP: if (sw_any) begin
          if (cnt_q == SKIP_LAST) begin
            st_d  = ST_SSLOW;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SSLOW: if (!light_load) st_d = ST_RUN;
        ST_RUN:   st_d = ST_RUN;
        ST_DEEP: if (sw_any) begin
          st_d  = ST_EXIT;
          cnt_d = CW'(1);
        end
        ST_EXIT: if (sw_any) begin
          if (cnt_q == EXIT_LAST) begin
            st_d  = ST_RUN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = ST_DEEP;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SKIP;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign gate_run = (st_q == ST_SSLOW) || (st_q == ST_RUN);
  assign soft_low = (st_q == ST_SSLOW);
  assign in_deep  = (st_q == ST_DEEP) || (st_q == ST_EXIT);
endmodule

// File: rtl/sis_gate_level.sv
module sis_gate_level (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_run,
  input  logic soft_low,
  input  logic prot_trip,
  input  logic light_load,
  input  logic ot_hot,
  input  logic ot_clear,
  output logic gate_en,
  output logic gate_low_v
);
  logic ot_q, ot_d;

  always_comb begin
    ot_d = ot_q;
    if (ot_hot)        ot_d = 1'b1;
    else if (ot_clear) ot_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ot_q <= 1'b0;
    else        ot_q <= ot_d;
  end

  assign gate_en    = gate_run && !prot_trip;
  assign gate_low_v = soft_low || light_load || ot_hot || ot_q;
endmodule

// File: rtl/sr_idle_seq.sv
module sr_idle_seq #(
  parameter int PRESCALE     = 250,
  parameter int IDLE1_TICKS  = 6000,
  parameter int IDLE2_TICKS  = 60000,
  parameter int PULSE_CYCLES = 25,
  parameter int SKIP_CYCLES  = 256,
  parameter int EXIT_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_strobe_a,
  input  logic sw_strobe_b,
  input  logic cond_a,
  input  logic cond_b,
  input  logic light_load,
  input  logic prot_trip,
  input  logic ot_hot,
  input  logic ot_clear,
  output logic gate_en,
  output logic gate_low_v,
  output logic dly_en,
  output logic loop_rst_pulse,
  output logic idle_shallow,
  output logic idle_deep
);
  logic sw_any, active, quiet;
  logic shallow_trig, deep_trig;
  logic gate_run, soft_low;

  assign sw_any = sw_strobe_a || sw_strobe_b;
  assign active = sw_any || cond_a || cond_b;
  assign quiet  = !active;

  sis_idle_timer #(
    .PRESCALE(PRESCALE), .IDLE1_TICKS(IDLE1_TICKS), .IDLE2_TICKS(IDLE2_TICKS)
  ) timer_i (
    .clk(clk), .rst_n(rst_n), .quiet(quiet),
    .shallow_trig(shallow_trig), .deep_trig(deep_trig)
  );

  sis_loop_reset #(.PULSE_CYCLES(PULSE_CYCLES)) lrst_i (
    .clk(clk), .rst_n(rst_n), .shallow_trig(shallow_trig), .active(active),
    .sw_any(sw_any), .light_load(light_load), .loop_rst_pulse(loop_rst_pulse),
    .idle_shallow(idle_shallow), .dly_en(dly_en)
  );

  sis_seq_fsm #(.SKIP_CYCLES(SKIP_CYCLES), .EXIT_CYCLES(EXIT_CYCLES)) fsm_i (
    .clk(clk), .rst_n(rst_n), .sw_any(sw_any), .light_load(light_load),
    .prot_trip(prot_trip), .deep_trig(deep_trig), .gate_run(gate_run),
    .soft_low(soft_low), .in_deep(idle_deep)
  );

  sis_gate_level lvl_i (
    .clk(clk), .rst_n(rst_n), .gate_run(gate_run), .soft_low(soft_low),
    .prot_trip(prot_trip), .light_load(light_load), .ot_hot(ot_hot),
    .ot_clear(ot_clear), .gate_en(gate_en), .gate_low_v(gate_low_v)
  );
endmodule

// File: rtl/sr_idle_seq_chk.sv
module sr_idle_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_strobe_a,
  input logic sw_strobe_b,
  input logic cond_a,
  input logic cond_b,
  input logic light_load,
  input logic prot_trip,
  input logic gate_en,
  input logic gate_low_v,
  input logic dly_en,
  input logic loop_rst_pulse,
  input logic idle_shallow,
  input logic idle_deep
);
  assert_prot_deep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prot_trip |=> idle_deep);

  assert_deep_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_deep |-> !gate_en);

  assert_pulse_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_rst_pulse) |-> idle_shallow);

  assert_pulse_dly_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_rst_pulse) |-> dly_en);

  assert_exit_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_deep) |-> (gate_en || prot_trip));

  assert_lowv_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    light_load |-> gate_low_v);

  assert_shallow_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_strobe_a || sw_strobe_b || cond_a || cond_b) |=> !idle_shallow);
endmodule

bind sr_idle_seq sr_idle_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sw_strobe_a(sw_strobe_a), .sw_strobe_b(sw_strobe_b),
  .cond_a(cond_a), .cond_b(cond_b), .light_load(light_load), .prot_trip(prot_trip),
  .gate_en(gate_en), .gate_low_v(gate_low_v), .dly_en(dly_en),
  .loop_rst_pulse(loop_rst_pulse), .idle_shallow(idle_shallow), .idle_deep(idle_deep)
);

// File: tb/sr_idle_seq_tb_top.sv
`timescale 1ns/1ps
module sr_idle_seq_tb_top;
  localparam int P_PRE  = 4;
  localparam int P_I1   = 10;
  localparam int P_I2   = 40;
  localparam int P_PUL  = 3;
  localparam int P_SKIP = 8;
  localparam int P_EXIT = 4;
  localparam int Q1 = P_I1 * P_PRE;
  localparam int Q2 = P_I2 * P_PRE;

  logic clk, rst_n;
  logic i_a, i_b, i_ca, i_cb, i_ll, i_prot, i_hot, i_clr;
  logic gate_en, gate_low_v, dly_en, loop_rst_pulse, idle_shallow, idle_deep;

  int checks, failures;
  bit done;

  int m_st, m_cnt, m_q, m_pl;
  bit m_sh, m_dly, m_ot;

  sr_idle_seq #(
    .PRESCALE(P_PRE), .IDLE1_TICKS(P_I1), .IDLE2_TICKS(P_I2),
    .PULSE_CYCLES(P_PUL), .SKIP_CYCLES(P_SKIP), .EXIT_CYCLES(P_EXIT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sw_strobe_a(i_a), .sw_strobe_b(i_b),
    .cond_a(i_ca), .cond_b(i_cb), .light_load(i_ll), .prot_trip(i_prot),
    .ot_hot(i_hot), .ot_clear(i_clr), .gate_en(gate_en), .gate_low_v(gate_low_v),
    .dly_en(dly_en), .loop_rst_pulse(loop_rst_pulse),
    .idle_shallow(idle_shallow), .idle_deep(idle_deep)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit e_gate();
    return ((m_st == 1) || (m_st == 2)) && !i_prot;
  endfunction
  function automatic bit e_low();
    return (m_st == 1) || i_ll || i_hot || m_ot;
  endfunction

  task automatic compare_all();
    chk("R2/R6/R7/R8 gate_en", gate_en, e_gate());
    chk("R2/R3/R9 gate_low_v", gate_low_v, e_low());
    chk("R5 dly_en", dly_en, m_dly);
    chk("R4 loop_rst_pulse", loop_rst_pulse, m_pl > 0);
    chk("R5/R10 idle_shallow", idle_shallow, m_sh);
    chk("R6/R7 idle_deep", idle_deep, (m_st == 3) || (m_st == 4));
  endtask

  task automatic model_reset();
    m_st = 0; m_cnt = 0; m_q = 0; m_pl = 0; m_sh = 0; m_dly = 0; m_ot = 0;
  endtask

  task automatic model_step();
    bit quiet, sw, hit1, hit2;
    sw    = i_a || i_b;
    quiet = !(sw || i_ca || i_cb);
    hit1 = 0; hit2 = 0;
    if (!quiet) m_q = 0;
    else if (m_q < Q2) begin
      m_q++;
      hit1 = (m_q == Q1);
      hit2 = (m_q == Q2);
    end
    if (hit1) m_pl = P_PUL; else if (m_pl > 0) m_pl--;
    if (!quiet) m_sh = 0; else if (hit1) m_sh = 1;
    if (hit1) m_dly = 1; else if (sw && !i_ll) m_dly = 0;
    if (i_hot) m_ot = 1; else if (i_clr) m_ot = 0;
    if (i_prot || (hit2 && m_st != 3)) begin
      m_st = 3; m_cnt = 0;
    end else begin
      case (m_st)
        0: if (sw) begin
             if (m_cnt == P_SKIP - 1) begin m_st = 1; m_cnt = 0; end
             else m_cnt++;
           end
        1: if (!i_ll) m_st = 2;
        3: if (sw) begin m_st = 4; m_cnt = 1; end
        4: if (sw) begin
             if (m_cnt == P_EXIT - 1) begin m_st = 2; m_cnt = 0; end
             else m_cnt++;
           end
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input bit a, input bit b, input bit ca, input bit cb,
                     input bit prot, input bit hot, input bit clr);
    @(negedge clk);
    i_a = a; i_b = b; i_ca = ca; i_cb = cb; i_prot = prot; i_hot = hot; i_clr = clr;
    #1 compare_all();
    @(posedge clk);
    #1 model_step();
  endtask

  task automatic quiet_n(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0;
    i_a = 0; i_b = 0; i_ca = 0; i_cb = 0; i_ll = 0; i_prot = 0; i_hot = 0; i_clr = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset gate_en", gate_en, 1'b0);
    chk("R1 reset dly_en", dly_en, 1'b0);
    chk("R1 reset pulse", loop_rst_pulse, 1'b0);
    chk("R1 reset idle_shallow", idle_shallow, 1'b0);
    chk("R1 reset idle_deep", idle_deep, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: soft-start skip counts strobes on either channel
    i_ll = 1;
    for (int k = 0; k < P_SKIP - 1; k++) cyc(k[0], !k[0], 0, 0, 0, 0, 0);
    chk("R2 gate held off during skip", gate_en, 1'b0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R2 gate on after skip", gate_en, 1'b1);
    chk("R2 low voltage after skip", gate_low_v, 1'b1);

    // R3: soft-start low phase ends with light load low
    i_ll = 0;
    quiet_n(1);
    chk("R3 low voltage released", gate_low_v, 1'b0);

    // R4/R5: shallow timeout pulse
    cyc(0, 1, 0, 0, 0, 0, 0);
    quiet_n(Q1 - 1);
    chk("R4 no pulse before timeout", loop_rst_pulse, 1'b0);
    quiet_n(1);
    chk("R4 pulse at timeout", loop_rst_pulse, 1'b1);
    chk("R5 shallow flag set", idle_shallow, 1'b1);
    chk("R5 dly_en set", dly_en, 1'b1);
    quiet_n(P_PUL - 1);
    chk("R4 pulse length", loop_rst_pulse, 1'b1);
    quiet_n(1);
    chk("R4 pulse ended", loop_rst_pulse, 1'b0);

    // R6: deep timeout
    quiet_n(Q2 - Q1 - P_PUL - 1);
    chk("R6 not deep yet", idle_deep, 1'b0);
    chk("R4 pulse not repeated", loop_rst_pulse, 1'b0);
    quiet_n(1);
    chk("R6 deep entered", idle_deep, 1'b1);
    chk("R6 gate off in deep", gate_en, 1'b0);

    // R7/R10: exit counting
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R10 shallow cleared", idle_shallow, 1'b0);
    for (int k = 0; k < P_EXIT - 2; k++) cyc(0, 1, 0, 0, 0, 0, 0);
    chk("R7 gate still off", gate_en, 1'b0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    chk("R7 gate on after exit", gate_en, 1'b1);
    chk("R7 deep cleared", idle_deep, 1'b0);

    // R8: protection
    @(negedge clk);
    i_prot = 1;
    #1 chk("R8 gate off same cycle", gate_en, 1'b0);
    @(posedge clk); #1 model_step();
    chk("R8 deep after trip", idle_deep, 1'b1);
    for (int k = 0; k < P_EXIT; k++) cyc(1, 0, 0, 0, 0, 0, 0);

    // R9: over-temperature latch
    cyc(1, 0, 0, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk("R9 latched low voltage", gate_low_v, 1'b1);
    cyc(1, 0, 0, 0, 0, 0, 1);
    chk("R9 released by clear", gate_low_v, 1'b0);

    // R4: conduction flag holds the timer
    for (int k = 0; k < Q2 + 10; k++) cyc(0, 0, k[2], !k[2], 0, 0, 0);
    chk("R4 conduction holds timer", idle_shallow, 1'b0);

    // Random segments
    void'($urandom(32'd4242));
    for (int seg = 0; seg < 160; seg++) begin
      int kind, len;
      kind = $urandom_range(0, 9);
      if (kind < 5) begin
        len = $urandom_range(10, 70);
        for (int k = 0; k < len; k++) begin
          if ($urandom_range(0, 40) == 0) i_ll = !i_ll;
          cyc($urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
              $urandom_range(0, 6) == 0, $urandom_range(0, 6) == 0,
              $urandom_range(0, 250) == 0, $urandom_range(0, 150) == 0,
              $urandom_range(0, 15) == 0);
        end
      end else if (kind < 9) begin
        len = $urandom_range(20, Q2 + 40);
        for (int k = 0; k < len; k++)
          cyc(0, 0, 0, 0, 0, 0, $urandom_range(0, 20) == 0);
      end else begin
        len = $urandom_range(1, 4);
        for (int k = 0; k < len; k++) cyc(1, 0, 0, 0, 1, 0, 0);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule